// File: doc/BRIEF.md
# Dual-Mode SPI Serial-Clock Divider

This block derives the serial-clock timing of an SPI controller from the bus clock. It does not produce a clock. It produces a one-cycle enable, `sclk_tick`, at every serial-clock edge, and a level flag, `sclk_phase`, that holds the current serial-clock level for the shift engine. The half-period length comes from an 8-bit divider value `div_val` and a mode bit `mode_lin`. With `mode_lin` low, the serial clock is the bus clock divided by 2^(N+1). With `mode_lin` high, it is the bus clock divided by 2·(N+1). The mode bit is expected to come from a control register and the divider value from a register of its own. Computing N from a target frequency is left to software.

A three-state machine controls the sequencing:

- `ST_HOLD`: `run` is low.
- `ST_LOW`: running, clock level low.
- `ST_HIGH`: running, clock level high.

Transitions:

- Hold-exit: `ST_HOLD` goes to `ST_LOW` or `ST_HIGH` when `run` is high.
- Rise: `ST_LOW` goes to `ST_HIGH` when a half-period ends.
- Fall: `ST_HIGH` goes to `ST_LOW` when a half-period ends.
- Stop: any state goes to `ST_HOLD` when `run` is low.

While in hold, the half-period counter reloads on every cycle. It reloads again at each half-period boundary. At that boundary it takes the divider and mode present on the inputs at that moment.

Top module: `spi_sclk_divider`

## Requirements
- R1: During reset and in the first cycle after it, `sclk_tick` and `sclk_phase` are both 0.
- R2: A clock edge that samples `run` low puts the block in hold. After that edge `sclk_tick` and `sclk_phase` are 0 and the counter is reloaded, so a stop part-way through a half-period leaves no trace on the next start.
- R3: With `mode_lin`=0 and N≤15, consecutive ticks are exactly 2^N bus cycles apart, which gives a serial-clock period of 2^(N+1) cycles.
- R4: With `mode_lin`=0, any N above 15 acts as 15, so ticks are 32768 cycles apart.
- R5: With `mode_lin`=1, consecutive ticks are N+1 cycles apart for any N from 0 to 255, which gives a period of 2·(N+1) cycles.
- R6: With N=0 in either mode, `sclk_tick` is high on every bus cycle while running. The toggle rate then equals the bus clock rate.
- R7: Call k the first edge that samples `run` high after a hold, and h the half-period that the inputs give at the edge before k. The first tick is registered at edge k+h−1, a full half-period after the start.
- R8: `sclk_phase` starts at 0, inverts on every cycle in which `sclk_tick` is 1, and does not change on any other running cycle.
- R9: A change to `div_val` or `mode_lin` during a half-period does not alter that half-period. It sets the length of the half-period that starts at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val | input | 8 | Divider value N |
| mode_lin | input | 1 | 0: power-of-two divide, 1: linear even divide |
| run | input | 1 | High while the serial clock should run |
| sclk_tick | output | 1 | One-cycle enable at each serial-clock edge |
| sclk_phase | output | 1 | Current serial-clock level (0 after hold) |

## Verification
Both outputs are registered. A tick for a given edge therefore appears right after the bus edge that ends the half-period. With a start on the negative edge at cycle count c, the ticks are due at counts c+h, c+2h, and so on. Outputs return to zero one edge after `run` is sampled low.

The driver computes these due counts from the requirement formulas and queues them. The monitor samples on the falling edge, pops one entry for each tick, and compares both the cycle count and the phase. A tick that arrives with no entry queued fails, and so does an entry still queued after a stop.

The driver sets the divider and mode one cycle before raising `run`. That keeps the hold-cycle reload defined for R7.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sclk_state_e;

endpackage

// File: rtl/sclk_reload_calc.sv
module sclk_reload_calc #(
    parameter int DIV_W   = 8,
    parameter int POW_MAX = 15,
    parameter int CNT_W   = 16
) (
    input  logic [DIV_W-1:0] div_val,
    input  logic             mode_lin,
    output logic [CNT_W-1:0] reload_val
);
    localparam int SH_W = $clog2(POW_MAX + 1);

    logic [SH_W-1:0]  shamt;
    logic [CNT_W-1:0] pow_val;
    logic [CNT_W-1:0] lin_val;

    // exponent clamp for the power-of-two scheme
    always_comb begin
        if (div_val > DIV_W'(POW_MAX))
            shamt = SH_W'(POW_MAX);
        else
            shamt = div_val[SH_W-1:0];
    end

    assign pow_val = (CNT_W'(1) << shamt) - CNT_W'(1);

    generate
        if (CNT_W > DIV_W) begin : g_lin_ext
            assign lin_val = {{(CNT_W-DIV_W){1'b0}}, div_val};
        end else begin : g_lin_same
            assign lin_val = div_val[CNT_W-1:0];
        end
    endgenerate

    // counter holds half-period minus one
    assign reload_val = mode_lin ? lin_val : pow_val;

endmodule

// File: rtl/sclk_halfcnt.sv
module sclk_halfcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sclk_edge_fsm.sv
module sclk_edge_fsm
    import sclk_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cnt_zero,
    output logic cnt_load,
    output logic cnt_dec,
    output logic tick,
    output logic phase
);
    sclk_state_e state_q, state_d;
    logic        tick_q, tick_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            tick_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            tick_q  <= tick_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        tick_d  = 1'b0;
        if (!run) begin
            state_d = ST_HOLD;                 // stop
        end else begin
            unique case (state_q)
                ST_HOLD, ST_LOW: begin
                    if (cnt_zero) begin
                        state_d = ST_HIGH;     // rise
                        tick_d  = 1'b1;
                    end else begin
                        state_d = ST_LOW;      // hold-exit / keep low
                    end
                end
                ST_HIGH: begin
                    if (cnt_zero) begin
                        state_d = ST_LOW;      // fall
                        tick_d  = 1'b1;
                    end
                end
                default: state_d = ST_HOLD;
            endcase
        end
    end

    // outputs
    always_comb begin
        cnt_load = !run || cnt_zero;
        cnt_dec  = run && !cnt_zero;
        tick     = tick_q;
        phase    = (state_q == ST_HIGH);
    end

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
    parameter int DIV_W   = 8,
    parameter int POW_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    input  logic             mode_lin,
    input  logic             run,
    output logic             sclk_tick,
    output logic             sclk_phase
);
    localparam int CNT_W = ((POW_MAX > DIV_W) ? POW_MAX : DIV_W) + 1;

    logic [CNT_W-1:0] reload_val;
    logic             cnt_zero;
    logic             cnt_load;
    logic             cnt_dec;

    sclk_reload_calc #(
        .DIV_W  (DIV_W),
        .POW_MAX(POW_MAX),
        .CNT_W  (CNT_W)
    ) u_reload (
        .div_val   (div_val),
        .mode_lin  (mode_lin),
        .reload_val(reload_val)
    );

    sclk_halfcnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .dec     (cnt_dec),
        .load_val(reload_val),
        .zero    (cnt_zero)
    );

    sclk_edge_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cnt_zero(cnt_zero),
        .cnt_load(cnt_load),
        .cnt_dec (cnt_dec),
        .tick    (sclk_tick),
        .phase   (sclk_phase)
    );

endmodule

// File: rtl/sclk_divider_checker.sv
module sclk_divider_checker (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic sclk_tick,
    input logic sclk_phase
);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!sclk_tick && !sclk_phase));

    assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_tick |-> $past(run));

    assert_tick_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_tick |-> (sclk_phase != $past(sclk_phase)));

    assert_hold_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !sclk_tick) |-> $stable(sclk_phase));

endmodule

bind spi_sclk_divider sclk_divider_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sclk_tick (sclk_tick),
    .sclk_phase(sclk_phase)
);

// File: tb/spi_sclk_divider_bench.sv
`timescale 1ns/1ps
module spi_sclk_divider_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic       mode_lin = 1'b0;
    logic       run = 1'b0;
    logic       sclk_tick;
    logic       sclk_phase;

    always #4 clk = ~clk;

    spi_sclk_divider u_spi_sclk_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_val   (div_val),
        .mode_lin  (mode_lin),
        .run       (run),
        .sclk_tick (sclk_tick),
        .sclk_phase(sclk_phase)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 0;
    int    q_cyc[$];
    bit    q_ph[$];
    string q_req[$];

    function automatic int half_period(bit m, int d);
        if (m) return d + 1;
        return 1 << ((d > 15) ? 15 : d);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per observed tick
    always @(negedge clk) begin
        if (rst_n && sclk_tick && !done) begin
            if (q_cyc.size() == 0) begin
                check(1'b0, "R8", "unexpected tick at cycle", cyc, -1);
            end else begin
                int    ec;
                bit    ep;
                string er;
                ec = q_cyc.pop_front();
                ep = q_ph.pop_front();
                er = q_req.pop_front();
                check(cyc == ec, er, "tick cycle", cyc, ec);
                check(sclk_phase == ep, er, "phase after tick", int'(sclk_phase), int'(ep));
            end
        end
    end

    task automatic push_exp(int c, bit ph, string req);
        q_cyc.push_back(c);
        q_ph.push_back(ph);
        q_req.push_back(req);
    endtask

    task automatic wait_cyc(int target);
        while (cyc != target) @(negedge clk);
    endtask

    // run was just lowered at this negedge
    task automatic stop_check();
        @(negedge clk);
        check(!sclk_tick && !sclk_phase, "R2", "outputs after stop",
              int'({sclk_tick, sclk_phase}), 0);
        repeat (3) @(negedge clk);
        check(q_cyc.size() == 0, "R2", "ticks still due after stop", q_cyc.size(), 0);
    endtask

    task automatic burst(bit m, int d, int nt, int extra, string req);
        int c;
        int hp;
        @(negedge clk);
        mode_lin = m;
        div_val  = d[7:0];
        @(negedge clk);
        run = 1'b1;
        c  = cyc;
        hp = half_period(m, d);
        for (int j = 1; j <= nt; j++) push_exp(c + hp * j, j[0], req);
        wait_cyc(c + hp * nt + extra);
        run = 1'b0;
        stop_check();
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        check(!sclk_tick && !sclk_phase, "R1", "outputs in reset",
              int'({sclk_tick, sclk_phase}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sclk_tick && !sclk_phase, "R1", "outputs after reset",
              int'({sclk_tick, sclk_phase}), 0);

        burst(1'b0, 0, 6, 0, "R6");      // power-of-two, fastest
        burst(1'b1, 0, 5, 0, "R6");      // linear, fastest
        burst(1'b0, 3, 4, 0, "R3");      // half-period 8
        burst(1'b1, 5, 4, 0, "R5");      // half-period 6
        burst(1'b1, 255, 2, 0, "R5");    // half-period 256
        burst(1'b0, 15, 1, 0, "R3");     // half-period 32768
        burst(1'b0, 200, 2, 0, "R4");    // clamped to 15
        burst(1'b1, 9, 0, 5, "R2");      // stop mid half-period
        burst(1'b1, 9, 2, 0, "R7");      // restart: full half-period again

        // R9: mid-period changes apply at the next boundary
        @(negedge clk);
        mode_lin = 1'b1;
        div_val  = 8'd3;
        @(negedge clk);
        run = 1'b1;
        c = cyc;
        push_exp(c + 4,   1'b1, "R9");
        push_exp(c + 12,  1'b0, "R9");
        push_exp(c + 20,  1'b1, "R9");
        push_exp(c + 148, 1'b0, "R9");
        wait_cyc(c + 2);
        div_val = 8'd7;
        wait_cyc(c + 14);
        mode_lin = 1'b0;
        wait_cyc(c + 148);
        run = 1'b0;
        stop_check();

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule